// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block runs one command at a time against a serial NOR flash on a single-lane SPI bus. Software fills a small set of 32-bit registers and then sets a go bit. Each command has an 8-bit opcode phase, then an optional address phase of one to four bytes, then an optional read phase of one to eight bytes. The sequencer drives chip select, the serial clock and the outbound data line, and samples the inbound data line. It packs the bytes it captures into a pair of read-data words.

The registers are chosen by a 3-bit word index:

| Index | Register |
|---|---|
| 0 | configuration (enable, clock divisor, idle status) |
| 1 | command control |
| 2 | command address |
| 3 | read-data low |
| 4 | read-data high |

Writes take effect on the clock edge that samples `reg_we`. Reads are combinational on `reg_idx`. Software polls the busy bit, or the idle bit, to learn when a command has finished, including the chip-select recovery time.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `flash_cs_n` is 1 and `flash_sclk` and `flash_mosi` are 0. Every register reads 0, except configuration bit 31, which reads 1.
- R2: Writing index 1 with bit 0 set starts a command only if configuration bit 0 (enable) is 1 and no command is in progress. With enable clear, no bus activity follows, but the command fields are still stored and read back.
- R3: Command-control bit 1 reads 1, and configuration bit 31 reads 0, from the edge that starts a command until the chip-select recovery time has ended.
- R4: While a command is in progress, every write to index 1 is ignored. It does not restart the command and it does not change the stored fields.
- R5: The opcode in command-control bits 31:24 is sent first, most significant bit first.
- R6: When command-control bit 19 is set, an address phase of (bits 17:16)+1 bytes follows the opcode. The address comes from index 2, is sent most significant enabled byte first, and each byte is sent MSB first.
- R7: When command-control bit 23 is set, a read phase of (bits 22:20)+1 bytes follows. The inbound line is sampled on each rising SCLK edge. The first bit of each byte is its MSB. Byte i lands in bits 8i+7:8i of the pair: bytes 0 to 3 go to index 3 and bytes 4 to 7 go to index 4.
- R8: Both read-data words clear when a command starts, so any byte not read by the latest command reads as 0.
- R9: With configuration bits 22:19 equal to n, each half of the SCLK period lasts n+1 reference cycles, which gives division ratios from 2 to 32. The divisor is latched when a command starts.
- R10: The bus runs in SPI mode 0. SCLK idles low. MOSI changes only when a low half starts and holds during each high half. MOSI is 0 during the read phase and whenever chip select is high.
- R11: Chip select falls on the start edge, n+1 cycles before the first rising SCLK edge. It rises on the same edge as the last falling SCLK edge. The command then stays busy for 2(n+1) further cycles with chip select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sclk | output | 1 | Serial clock |
| flash_mosi | output | 1 | Data to the flash |
| flash_miso | input | 1 | Data from the flash |

## Verification
The hardest case to reach from the ports is a go-bit write that lands while a command is still shifting. That write carries a different opcode, so a wrongful restart or field overwrite would show up either in the pin waveform or in the read-back. The stimulus widens the window with the slowest divisor. It then issues the competing write mid-command and compares every pin on every cycle against a waveform queue that the bench built from the original command. Back-to-back commands with no gap in the software check that the recovery period with chip select high is always present.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   // register word indices
   localparam int REG_IDX_W = 3;
   localparam logic [REG_IDX_W-1:0] IDX_CFG  = 3'd0;
   localparam logic [REG_IDX_W-1:0] IDX_CTRL = 3'd1;
   localparam logic [REG_IDX_W-1:0] IDX_ADDR = 3'd2;
   localparam logic [REG_IDX_W-1:0] IDX_RDLO = 3'd3;
   localparam logic [REG_IDX_W-1:0] IDX_RDHI = 3'd4;

   // configuration word layout
   localparam int CFG_EN_BIT   = 0;
   localparam int CFG_DIV_LSB  = 19;
   localparam int CFG_IDLE_BIT = 31;

   // command control word layout
   localparam int CTL_GO_BIT   = 0;
   localparam int CTL_BUSY_BIT = 1;
   localparam int CTL_ALEN_LSB = 16;
   localparam int CTL_AEN_BIT  = 19;
   localparam int CTL_RLEN_LSB = 20;
   localparam int CTL_REN_BIT  = 23;
   localparam int CTL_OP_LSB   = 24;

   typedef struct packed {
      logic [7:0] op;
      logic       rd_en;
      logic [2:0] rd_len;
      logic       ad_en;
      logic [1:0] ad_len;
   } cmd_fields_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_GUARD = 2'd2
   } eng_state_t;

endpackage

// File: rtl/fcs_regs.sv
module fcs_regs
   import flash_cmd_pkg::*;
#(
   parameter int DIV_W    = 4,
   parameter int AD_BYTES = 4,
   parameter int RD_BYTES = 8,
   localparam int AD_W  = 8 * AD_BYTES,
   localparam int TX_W  = 8 + AD_W,
   localparam int RX_W  = 8 * RD_BYTES,
   localparam int CNT_W = $clog2(8 * (1 + AD_BYTES + RD_BYTES) + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [REG_IDX_W-1:0] idx,
   input  logic [31:0]          wdata,
   output logic [31:0]          rdata,
   input  logic                 busy,
   input  logic [RX_W-1:0]      rx_data,
   output logic                 start,
   output logic [DIV_W-1:0]     div,
   output logic [TX_W-1:0]      tx_load,
   output logic [CNT_W-1:0]     n_bits,
   output logic [CNT_W-1:0]     rd_first
);

   logic              cfg_en_q;
   logic [DIV_W-1:0]  cfg_div_q;
   logic [31:0]       addr_q;
   cmd_fields_t       fld_q;
   cmd_fields_t       fld_wr;
   cmd_fields_t       fld_nxt;
   logic              ctrl_wr;
   logic [AD_W-1:0]   ad_vec;

   assign ctrl_wr = we && (idx == IDX_CTRL);

   always_comb begin
      fld_wr.op     = wdata[CTL_OP_LSB +: 8];
      fld_wr.rd_en  = wdata[CTL_REN_BIT];
      fld_wr.rd_len = wdata[CTL_RLEN_LSB +: 3];
      fld_wr.ad_en  = wdata[CTL_AEN_BIT];
      fld_wr.ad_len = wdata[CTL_ALEN_LSB +: 2];
   end

   // a write to the control word while busy is dropped in full
   assign fld_nxt = (ctrl_wr && !busy) ? fld_wr : fld_q;
   assign start   = ctrl_wr && wdata[CTL_GO_BIT] && !busy && cfg_en_q;
   assign div     = cfg_div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_en_q  <= 1'b0;
         cfg_div_q <= '0;
         addr_q    <= '0;
         fld_q     <= '0;
      end else begin
         fld_q <= fld_nxt;
         if (we && (idx == IDX_CFG)) begin
            cfg_en_q  <= wdata[CFG_EN_BIT];
            cfg_div_q <= wdata[CFG_DIV_LSB +: DIV_W];
         end
         if (we && (idx == IDX_ADDR)) begin
            addr_q <= wdata;
         end
      end
   end

   // address bytes left-aligned so the highest enabled byte leaves first
   always_comb begin
      ad_vec = '0;
      if (fld_nxt.ad_en) begin
         ad_vec = addr_q[AD_W-1:0] << (8 * (AD_BYTES - 1 - int'(fld_nxt.ad_len)));
      end
   end

   assign tx_load = {fld_nxt.op, ad_vec};

   always_comb begin
      int nb;
      int rf;
      nb = 8;
      if (fld_nxt.ad_en) begin
         nb = nb + 8 * (int'(fld_nxt.ad_len) + 1);
      end
      rf = nb;
      if (fld_nxt.rd_en) begin
         nb = nb + 8 * (int'(fld_nxt.rd_len) + 1);
      end
      n_bits   = CNT_W'(nb);
      rd_first = CNT_W'(rf);
   end

   always_comb begin
      rdata = '0;
      case (idx)
         IDX_CFG: begin
            rdata[CFG_IDLE_BIT]              = !busy;
            rdata[CFG_DIV_LSB +: DIV_W]      = cfg_div_q;
            rdata[CFG_EN_BIT]                = cfg_en_q;
         end
         IDX_CTRL: begin
            rdata[CTL_OP_LSB +: 8]   = fld_q.op;
            rdata[CTL_REN_BIT]       = fld_q.rd_en;
            rdata[CTL_RLEN_LSB +: 3] = fld_q.rd_len;
            rdata[CTL_AEN_BIT]       = fld_q.ad_en;
            rdata[CTL_ALEN_LSB +: 2] = fld_q.ad_len;
            rdata[CTL_BUSY_BIT]      = busy;
         end
         IDX_ADDR: rdata = addr_q;
         IDX_RDLO: rdata = rx_data[31:0];
         IDX_RDHI: rdata = rx_data[63:32];
         default:  rdata = '0;
      endcase
   end

   // R4: stored command fields never move while a command is in progress
   a_r4_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(fld_q));

endmodule

// File: rtl/fcs_bit_engine.sv
module fcs_bit_engine
   import flash_cmd_pkg::*;
#(
   parameter int DIV_W = 4,
   parameter int TX_W  = 40,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DIV_W-1:0] div,
   input  logic [TX_W-1:0]  tx_load,
   input  logic [CNT_W-1:0] n_bits,
   input  logic [CNT_W-1:0] rd_first,
   input  logic             miso,
   output logic             busy,
   output logic             cs_n,
   output logic             sclk,
   output logic             mosi,
   output logic             sample_en,
   output logic             sample_bit
);

   localparam int HC_W = DIV_W + 1;

   eng_state_t        st_q;
   logic [HC_W-1:0]   hc_q;
   logic              ph_q;
   logic [CNT_W-1:0]  bit_q;
   logic [CNT_W-1:0]  nb_q;
   logic [CNT_W-1:0]  rf_q;
   logic [DIV_W-1:0]  div_q;
   logic [TX_W-1:0]   tx_q;
   logic              cs_q;
   logic              sck_q;
   logic              half_end;
   logic              guard_end;

   assign half_end  = (hc_q == {1'b0, div_q});
   assign guard_end = (hc_q == {div_q, 1'b1});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         hc_q  <= '0;
         ph_q  <= 1'b0;
         bit_q <= '0;
         nb_q  <= '0;
         rf_q  <= '0;
         div_q <= '0;
         tx_q  <= '0;
         cs_q  <= 1'b1;
         sck_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_q  <= ST_SHIFT;
                  cs_q  <= 1'b0;
                  sck_q <= 1'b0;
                  hc_q  <= '0;
                  ph_q  <= 1'b0;
                  bit_q <= '0;
                  tx_q  <= tx_load;
                  nb_q  <= n_bits;
                  rf_q  <= rd_first;
                  div_q <= div;
               end
            end
            ST_SHIFT: begin
               if (half_end) begin
                  hc_q <= '0;
                  if (!ph_q) begin
                     sck_q <= 1'b1;
                     ph_q  <= 1'b1;
                  end else begin
                     sck_q <= 1'b0;
                     ph_q  <= 1'b0;
                     tx_q  <= {tx_q[TX_W-2:0], 1'b0};
                     if (bit_q == nb_q - 1'b1) begin
                        st_q <= ST_GUARD;
                        cs_q <= 1'b1;
                     end else begin
                        bit_q <= bit_q + 1'b1;
                     end
                  end
               end else begin
                  hc_q <= hc_q + 1'b1;
               end
            end
            ST_GUARD: begin
               if (guard_end) begin
                  st_q <= ST_IDLE;
                  hc_q <= '0;
               end else begin
                  hc_q <= hc_q + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (st_q != ST_IDLE);
   assign cs_n       = cs_q;
   assign sclk       = sck_q;
   assign mosi       = tx_q[TX_W-1];
   assign sample_en  = (st_q == ST_SHIFT) && !ph_q && half_end && (bit_q >= rf_q);
   assign sample_bit = miso;

   // R10: the clock only moves while the device is selected
   a_r10_sclk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q |-> !sck_q);

   // R10: outbound data holds across each high half
   a_r10_mosi_holds_high: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_q && $past(sck_q)) |-> $stable(tx_q[TX_W-1]));

   // R3: a selected device always implies an active command
   a_r3_cs_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_q |-> busy);

endmodule

// File: rtl/fcs_rx_pack.sv
module fcs_rx_pack #(
   parameter int RD_BYTES = 8,
   localparam int RX_W = 8 * RD_BYTES,
   localparam int IW   = $clog2(RX_W)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            sample_en,
   input  logic            sample_bit,
   output logic [RX_W-1:0] data
);

   logic [IW-1:0] rb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rb_q <= '0;
      end else if (clear) begin
         rb_q <= '0;
      end else if (sample_en) begin
         rb_q <= rb_q + 1'b1;
      end
   end

   for (genvar b = 0; b < RD_BYTES; b++) begin : g_byte
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
         end else if (clear) begin
            byte_q <= '0;
         end else if (sample_en && (rb_q[IW-1:3] == (IW-3)'(b))) begin
            // first bit of a byte is its most significant bit
            byte_q[~rb_q[2:0]] <= sample_bit;
         end
      end
      assign data[8*b +: 8] = byte_q;
   end

   // R8: a capture never coincides with the clearing start edge
   a_r8_no_capture_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en |-> !clear);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import flash_cmd_pkg::*;
#(
   parameter int DIV_W    = 4,
   parameter int AD_BYTES = 4,
   parameter int RD_BYTES = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [2:0]  reg_idx,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        flash_cs_n,
   output logic        flash_sclk,
   output logic        flash_mosi,
   input  logic        flash_miso
);

   localparam int AD_W  = 8 * AD_BYTES;
   localparam int TX_W  = 8 + AD_W;
   localparam int RX_W  = 8 * RD_BYTES;
   localparam int CNT_W = $clog2(8 * (1 + AD_BYTES + RD_BYTES) + 1);

   // the register layout fixes these widths
   if (DIV_W != 4) begin : g_bad_div
      $error("DIV_W must match the 4-bit divisor field");
   end
   if (AD_BYTES != 4) begin : g_bad_ad
      $error("AD_BYTES must match the 2-bit address length field");
   end
   if (RD_BYTES != 8) begin : g_bad_rd
      $error("RD_BYTES must match the 3-bit read length field");
   end

   logic             busy;
   logic             start;
   logic [DIV_W-1:0] div;
   logic [TX_W-1:0]  tx_load;
   logic [CNT_W-1:0] n_bits;
   logic [CNT_W-1:0] rd_first;
   logic             sample_en;
   logic             sample_bit;
   logic [RX_W-1:0]  rx_data;

   fcs_regs #(
      .DIV_W   (DIV_W),
      .AD_BYTES(AD_BYTES),
      .RD_BYTES(RD_BYTES)
   ) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .idx     (reg_idx),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .busy    (busy),
      .rx_data (rx_data),
      .start   (start),
      .div     (div),
      .tx_load (tx_load),
      .n_bits  (n_bits),
      .rd_first(rd_first)
   );

   fcs_bit_engine #(
      .DIV_W(DIV_W),
      .TX_W (TX_W),
      .CNT_W(CNT_W)
   ) eng_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .div       (div),
      .tx_load   (tx_load),
      .n_bits    (n_bits),
      .rd_first  (rd_first),
      .miso      (flash_miso),
      .busy      (busy),
      .cs_n      (flash_cs_n),
      .sclk      (flash_sclk),
      .mosi      (flash_mosi),
      .sample_en (sample_en),
      .sample_bit(sample_bit)
   );

   fcs_rx_pack #(
      .RD_BYTES(RD_BYTES)
   ) pack_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (start),
      .sample_en (sample_en),
      .sample_bit(sample_bit),
      .data      (rx_data)
   );

   // R2: a command only begins when the enable bit was set
   a_r2_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(regs_i.cfg_en_q));

   // R11: busy ends only after chip select is already released
   a_r11_release_before_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (flash_cs_n && $past(flash_cs_n)));

endmodule

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_idx = 3'd0;
   logic [31:0] reg_wdata = '0;
   wire  [31:0] reg_rdata;
   wire         cs_n;
   wire         sclk;
   wire         mosi;
   logic        miso = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_cmd_seq dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_idx   (reg_idx),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .flash_cs_n(cs_n),
      .flash_sclk(sclk),
      .flash_mosi(mosi),
      .flash_miso(miso)
   );

   int vecs = 0;
   int errs = 0;
   bit mon_on = 1'b0;

   logic [2:0]   wq[$];        // expected {cs_n, sclk, mosi} per cycle
   logic [127:0] pat = '0;     // bit stream the flash model returns
   int           slot = 0;
   logic         prev_sck = 1'b0;

   logic [7:0]  c_op;
   bit          c_aen;
   int          c_al;
   logic [31:0] c_addr;
   bit          c_ren;
   int          c_rl;
   int          c_div;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // pin reference compared on every clock
   always @(negedge clk) begin
      if (mon_on) begin
         logic [2:0] e;
         e = (wq.size() != 0) ? wq.pop_front() : 3'b100;
         chk("R9/R10/R11 pins {cs_n,sclk,mosi}", {61'd0, cs_n, sclk, mosi}, {61'd0, e});
      end
   end

   // flash model: mode 0, next bit after each falling clock edge
   always @(negedge clk) begin
      if (cs_n) begin
         slot = 0;
         miso = pat[0];
      end else if (prev_sck && !sclk) begin
         slot++;
         miso = pat[slot[6:0]];
      end
      prev_sck = sclk;
   end

   function automatic logic [31:0] ctrl_word(input logic [7:0] op, input bit ren, input int rl,
                                             input bit aen, input int al, input bit go);
      logic [31:0] w;
      w = '0;
      w[31:24] = op;
      w[23]    = ren;
      w[22:20] = 3'(rl);
      w[19]    = aen;
      w[17:16] = 2'(al);
      w[0]     = go;
      return w;
   endfunction

   task automatic build_wave();
      bit bits[$];
      int h;
      for (int i = 7; i >= 0; i--) bits.push_back(c_op[i]);
      if (c_aen) begin
         for (int k = c_al; k >= 0; k--)
            for (int i = 7; i >= 0; i--) bits.push_back(c_addr[8*k+i]);
      end
      if (c_ren) begin
         for (int i = 0; i < 8*(c_rl+1); i++) bits.push_back(1'b0);
      end
      h = c_div + 1;
      foreach (bits[b]) begin
         for (int i = 0; i < h; i++) wq.push_back({1'b0, 1'b0, bits[b]});
         for (int i = 0; i < h; i++) wq.push_back({1'b0, 1'b1, bits[b]});
      end
      for (int i = 0; i < 2*h; i++) wq.push_back(3'b100);
   endtask

   task automatic write_reg(input logic [2:0] idx, input logic [31:0] data, input bit push);
      @(negedge clk);
      reg_idx   = idx;
      reg_wdata = data;
      reg_we    = 1'b1;
      @(posedge clk);
      if (push) build_wave();
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic read_reg(input logic [2:0] idx, output logic [31:0] val);
      @(negedge clk);
      reg_idx = idx;
      #1;
      val = reg_rdata;
   endtask

   task automatic wait_done();
      while (wq.size() != 0) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_cmd(input logic [7:0] op, input bit aen, input int al, input logic [31:0] addr,
                          input bit ren, input int rl, input int dv);
      c_op = op; c_aen = aen; c_al = al; c_addr = addr;
      c_ren = ren; c_rl = rl; c_div = dv;
      pat = {$urandom, $urandom, $urandom, $urandom};
      write_reg(3'd0, (32'(dv) << 19) | 32'd1, 1'b0);
      write_reg(3'd2, addr, 1'b0);
   endtask

   task automatic check_result(input string tag);
      logic [63:0] e;
      logic [31:0] v;
      int rdf;
      e = '0;
      rdf = 8 + (c_aen ? 8*(c_al+1) : 0);
      if (c_ren) begin
         for (int i = 0; i <= c_rl; i++)
            for (int j = 0; j < 8; j++) e[8*i+7-j] = pat[rdf+8*i+j];
      end
      read_reg(3'd1, v);
      chk({"R3 busy clear after ", tag}, {63'd0, v[1]}, 64'd0);
      read_reg(3'd0, v);
      chk({"R3 idle set after ", tag}, {63'd0, v[31]}, 64'd1);
      read_reg(3'd3, v);
      chk({"R7 low word ", tag}, {32'd0, v}, {32'd0, e[31:0]});
      read_reg(3'd4, v);
      chk({"R8 high word ", tag}, {32'd0, v}, {32'd0, e[63:32]});
   endtask

   task automatic run_cmd(input string tag, input logic [7:0] op, input bit aen, input int al,
                          input logic [31:0] addr, input bit ren, input int rl, input int dv);
      set_cmd(op, aen, al, addr, ren, rl, dv);
      write_reg(3'd1, ctrl_word(op, ren, rl, aen, al, 1'b1), 1'b1);
      wait_done();
      check_result(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      mon_on = 1'b1;

      // R1: reset state
      read_reg(3'd0, v); chk("R1 config", {32'd0, v}, 64'h8000_0000);
      read_reg(3'd1, v); chk("R1 control", {32'd0, v}, 64'd0);
      read_reg(3'd2, v); chk("R1 address", {32'd0, v}, 64'd0);
      read_reg(3'd3, v); chk("R1 read low", {32'd0, v}, 64'd0);
      read_reg(3'd4, v); chk("R1 read high", {32'd0, v}, 64'd0);
      chk("R1 pins", {61'd0, cs_n, sclk, mosi}, {61'd0, 3'b100});

      // R2: go with enable clear is dropped, fields still kept
      write_reg(3'd0, 32'd0, 1'b0);
      write_reg(3'd1, ctrl_word(8'h66, 1'b0, 0, 1'b0, 0, 1'b1), 1'b0);
      repeat (10) @(negedge clk);
      read_reg(3'd1, v);
      chk("R2 no start while disabled", {63'd0, v[1]}, 64'd0);
      chk("R2 fields stored", {56'd0, v[31:24]}, 64'h66);

      // R5: opcode only, fastest clock
      run_cmd("opcode only", 8'h06, 1'b0, 0, 32'd0, 1'b0, 0, 0);
      // R7 R8: one byte read, divisor 2
      run_cmd("one byte read", 8'h05, 1'b0, 0, 32'd0, 1'b1, 0, 2);
      // R6: four address bytes, no read
      run_cmd("four byte addr", 8'hDC, 1'b1, 3, 32'h1234_5678, 1'b0, 0, 1);
      // R6 R7: three address bytes, eight bytes read
      run_cmd("eight byte read", 8'h0C, 1'b1, 2, 32'h99AB_CDEF, 1'b1, 7, 0);
      // R9: slowest clock, one address byte, five bytes read
      run_cmd("ratio 32", 8'h03, 1'b1, 0, 32'hFFFF_FF5A, 1'b1, 4, 15);

      // R3 R4: busy readback and a competing write mid-command
      set_cmd(8'h0B, 1'b1, 2, 32'h0001_2345, 1'b1, 1, 15);
      write_reg(3'd1, ctrl_word(8'h0B, 1'b1, 1, 1'b1, 2, 1'b1), 1'b1);
      repeat (20) @(negedge clk);
      read_reg(3'd1, v);
      chk("R3 busy set mid-command", {63'd0, v[1]}, 64'd1);
      read_reg(3'd0, v);
      chk("R3 idle clear mid-command", {63'd0, v[31]}, 64'd0);
      write_reg(3'd1, ctrl_word(8'h9F, 1'b0, 0, 1'b0, 0, 1'b1), 1'b0);
      wait_done();
      read_reg(3'd1, v);
      chk("R4 opcode kept after busy write", {56'd0, v[31:24]}, 64'h0B);
      chk("R4 address enable kept", {63'd0, v[19]}, 64'd1);
      check_result("busy write");

      // R8: a command without read clears the earlier data
      run_cmd("after long read", 8'h0C, 1'b1, 3, 32'hA5A5_0F0F, 1'b1, 7, 1);
      run_cmd("clears data", 8'h04, 1'b0, 0, 32'd0, 1'b0, 0, 3);

      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

endmodule